// File: doc/BRIEF.md
# EDO DRAM Access Controller

This controller links a synchronous request port to an asynchronous DRAM with a multiplexed address bus. The DRAM holds one million 16-bit words. A request carries a 20-bit word address, a write flag, two byte-enable bits and write data. The controller splits the address into a 10-bit row and a 10-bit column. It presents both on one 10-bit bus and sequences the row strobe, the two byte-lane column strobes, write enable and output enable. Read data is captured a set number of cycles after the column strobe falls.

A row stays open while later requests hit the same row. In that case only the column strobes cycle, which gives an EDO page-mode burst. A miss or a pending refresh closes the row. The refresh request is served with a column-before-row refresh cycle, and it takes priority over a new access. Every interval (row-to-column delay, column pulse, column precharge, row precharge, refresh pulse, read sample point) is a parameter counted in clock cycles.

Top module: `edo_ctrl`

## Requirements
- R1: While the row strobe is high, output enable stays high and the data bus drive enable stays low, and all strobes are high out of reset.
- R2: Address bits 19:10 are the row, presented on the address bus when the row strobe falls. Bits 9:0 are the column, presented when a column strobe falls.
- R3: A read drives write enable high and output enable low during the column pulse. A write drives write enable low, and the data written is later read back unchanged.
- R4: Byte enable bit 0 selects the lower column strobe (data 7:0) and bit 1 the upper one (data 15:8). A lane left disabled is not written, and it returns zero on a read.
- R5: A request with both byte enables clear is accepted (req_ready pulses) but causes no strobe activity and no write.
- R6: Consecutive requests to the open row, with no refresh pending, reuse the open row without a new row strobe fall.
- R7: After the row strobe rises it stays high for at least T_RP cycles before it falls again, and a row miss closes and reopens the row.
- R8: For a write, write enable is already low in the cycle before a column strobe falls.
- R9: A held ref_req is served by lowering both column strobes, then the row strobe, for T_REF cycles. ref_ack pulses in the last cycle, and no data is changed.
- R10: A refresh pending while a row is open closes that row, so the next access to the same row opens it again.
- R11: rd_valid is a one-cycle pulse T_CAC cycles after the column strobe falls for a read.
- R12: wr_ack is a one-cycle pulse in the cycle in which the column strobe of a write rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in 19:10, column in 9:0 |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request taken this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| wr_ack | output | 1 | Write completed pulse |
| ref_req | input | 1 | Refresh wanted, held until ref_ack |
| ref_ack | output | 1 | Refresh finishing |
| dram_ras_n | output | 1 | Row strobe |
| dram_lcas_n | output | 1 | Lower-byte column strobe |
| dram_ucas_n | output | 1 | Upper-byte column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data to memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data from memory |

## Verification
The bench targets page bursts. A controller that reopened the row on every hit would show extra row strobe falls. One that kept the row open across a refresh would show too few. Byte-lane writes and reads are checked for damage to the other lane and for non-zero data in a masked lane. A request with both enables clear must pass with no column strobe at all. A memory model watches the strobes for write enable changing at the same moment as a column strobe falls, for a short row precharge gap, for rd_valid off its fixed offset from the column fall, and for wr_ack not matching the rising column strobe.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int RW = 10,
  parameter int CW = 10,
  parameter int DW = 16,
  parameter int T_RCD = 2,
  parameter int T_CAS = 3,
  parameter int T_CAC = 2,
  parameter int T_CP = 2,
  parameter int T_RP = 3,
  parameter int T_REF = 4,
  parameter int CNTW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [RW+CW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_ack,
  input  logic          ref_req,
  output logic          ref_ack,
  output logic          dram_ras_n,
  output logic          dram_lcas_n,
  output logic          dram_ucas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  output logic [RW-1:0] dram_addr,
  output logic [DW-1:0] dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_in
);
  localparam int AW = RW + CW;
  localparam int HW = DW / 2;
  localparam logic [CNTW-1:0] L_RCD = CNTW'(T_RCD - 1);
  localparam logic [CNTW-1:0] L_CAS = CNTW'(T_CAS - 1);
  localparam logic [CNTW-1:0] L_CP  = CNTW'(T_CP - 1);
  localparam logic [CNTW-1:0] L_RP  = CNTW'(T_RP - 1);
  localparam logic [CNTW-1:0] L_REF = CNTW'(T_REF - 1);
  localparam logic [CNTW-1:0] L_SMP = CNTW'(T_CAS - T_CAC);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CAS, S_CP, S_SU, S_RFC, S_RFR} st_t;

  st_t st;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [1:0] be_q;
  logic wr_q;
  logic [DW-1:0] wd_q;
  logic [CNTW-1:0] cnt, pre_cnt;

  wire [RW-1:0] req_row = req_addr[AW-1:CW];
  wire [CW-1:0] req_col = req_addr[CW-1:0];
  wire cnt_done = cnt == '0;
  wire pre_done = pre_cnt == '0;
  wire hit = req_valid && req_be != 2'b00 && req_row == row_q && !ref_req;
  wire start = st == S_IDLE && pre_done && !ref_req && req_valid;
  wire page = st == S_CP && cnt_done && hit;
  wire go_ref = st == S_IDLE && pre_done && ref_req;
  wire row_open = st == S_RCD || st == S_CAS || st == S_CP || st == S_SU;
  wire cas_acc = st == S_CAS;
  wire cas_ref = st == S_RFC || st == S_RFR;

  assign req_ready   = start || page;
  assign ref_ack     = st == S_RFR && cnt_done;
  assign dram_ras_n  = !(row_open || st == S_RFR);
  assign dram_lcas_n = !((cas_acc && be_q[0]) || cas_ref);
  assign dram_ucas_n = !((cas_acc && be_q[1]) || cas_ref);
  assign dram_we_n   = !(row_open && wr_q);
  assign dram_oe_n   = !(cas_acc && !wr_q);
  assign dram_addr   = (st == S_RCD) ? row_q : col_q;
  assign dram_dq_out = wd_q;
  assign dram_dq_oe  = row_open && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      row_q <= '0; col_q <= '0; be_q <= '0; wr_q <= 1'b0; wd_q <= '0;
      cnt <= '0; pre_cnt <= L_RP;
      rd_valid <= 1'b0; rd_data <= '0; wr_ack <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_ack <= 1'b0;
      if (req_ready) begin
        row_q <= req_row; col_q <= req_col; be_q <= req_be;
        wr_q <= req_write; wd_q <= req_wdata;
      end
      case (st)
        S_IDLE: begin
          if (!pre_done) pre_cnt <= pre_cnt - 1'b1;
          if (go_ref) st <= S_RFC;
          else if (start && req_be != 2'b00) begin
            st <= S_RCD; cnt <= L_RCD;
          end
        end
        S_RCD: if (cnt_done) begin st <= S_CAS; cnt <= L_CAS; end
               else cnt <= cnt - 1'b1;
        S_CAS: begin
          if (!wr_q && cnt == L_SMP) begin
            rd_data <= dram_dq_in & {{HW{be_q[1]}}, {HW{be_q[0]}}};
            rd_valid <= 1'b1;
          end
          if (cnt_done) begin
            st <= S_CP; cnt <= L_CP; wr_ack <= wr_q;
          end else cnt <= cnt - 1'b1;
        end
        S_CP: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (hit) st <= S_SU;
          else begin st <= S_IDLE; pre_cnt <= L_RP; end
        end
        S_SU: begin st <= S_CAS; cnt <= L_CAS; end
        S_RFC: begin st <= S_RFR; cnt <= L_REF; end
        S_RFR: if (cnt_done) begin st <= S_IDLE; pre_cnt <= L_RP; end
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module edo_ctrl_chk #(
  parameter int T_RP = 3,
  parameter int CNTW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic dram_ras_n,
  input logic dram_lcas_n,
  input logic dram_ucas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe,
  input logic rd_valid,
  input logic wr_ack
);
  logic [CNTW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != {CNTW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ras_n |-> (dram_oe_n && !dram_dq_oe));
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= CNTW'(T_RP));
  a_r8_early_we_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_lcas_n) && !dram_ras_n && !dram_we_n) |-> $past(!dram_we_n));
  a_r8_early_we_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ucas_n) && !dram_ras_n && !dram_we_n) |-> $past(!dram_we_n));
  a_r9_cbr_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> dram_lcas_n == dram_ucas_n);
  a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r12_ack_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (dram_lcas_n && dram_ucas_n));
endmodule

bind edo_ctrl edo_ctrl_chk #(.T_RP(T_RP), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
  .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dram_dq_oe(dram_dq_oe), .rd_valid(rd_valid), .wr_ack(wr_ack));

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int T_CAC = 2;
  localparam int T_RP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, wr_ack, ref_ack;
  logic [15:0] rd_data;
  logic ref_req = 1'b0;
  logic ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [9:0] dram_addr;
  logic [15:0] dq_out, dq_in;

  edo_ctrl u_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_ack(wr_ack), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int ras_falls = 0, cas_falls = 0, cbr = 0, acks = 0;
  int gap_viol = 0, early_viol = 0, stby_viol = 0, lat_viol = 0, lat_seen = 0, ack_viol = 0;
  int hi_run = 0, fall_cyc = 0;
  logic [15:0] mem [256];
  logic [9:0] row_m = '0, col_m = '0;
  logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
  wire [7:0] idx = {row_m[3:0], col_m[3:0]};

  assign dq_in = (!ras_n && !oe_n && we_n) ?
    {(!ucas_n ? mem[idx][15:8] : 8'h00), (!lcas_n ? mem[idx][7:0] : 8'h00)} : 16'h0000;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (ras_n && (dq_oe || !oe_n)) stby_viol++;
    if (p_ras && !ras_n) begin
      if (!p_l && !p_u) cbr++;
      else begin ras_falls++; row_m = dram_addr; end
      if (hi_run < T_RP) gap_viol++;
    end
    if (!ras_n && ((p_l && !lcas_n) || (p_u && !ucas_n))) begin
      cas_falls++;
      col_m = dram_addr;
      fall_cyc = cyc;
      if (!we_n) begin
        if (p_we) early_viol++;
        if (p_l && !lcas_n && dq_oe) mem[{row_m[3:0], dram_addr[3:0]}][7:0] = dq_out[7:0];
        if (p_u && !ucas_n && dq_oe) mem[{row_m[3:0], dram_addr[3:0]}][15:8] = dq_out[15:8];
      end
    end
    if (rd_valid) begin lat_seen++; if (cyc - fall_cyc != T_CAC) lat_viol++; end
    if (wr_ack) begin acks++; if (!((!p_l || !p_u) && lcas_n && ucas_n)) ack_viol++; end
    hi_run = ras_n ? hi_run + 1 : 0;
    p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic issue(input bit w, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    forever begin #1; if (req_ready) break; @(negedge clk); end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [1:0] be, output logic [15:0] q);
    issue(1'b0, a, be, 16'h0);
    forever begin @(negedge clk); if (rd_valid) break; end
    q = rd_data;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && !rd_valid, "R1 reset idle", {ras_n,lcas_n,ucas_n,we_n,oe_n}, 5'h1f);
  endtask

  task automatic t_word();
    logic [15:0] q;
    issue(1'b1, {10'd3, 10'd5}, 2'b11, 16'hA55A); settle();
    check(mem[{4'd3, 4'd5}] == 16'hA55A, "R2 row/col placement", mem[{4'd3,4'd5}], 16'hA55A);
    rd({10'd3, 10'd5}, 2'b11, q); settle();
    check(q == 16'hA55A, "R3 word read back", q, 16'hA55A);
  endtask

  task automatic t_bytes();
    logic [15:0] q;
    issue(1'b1, {10'd4, 10'd2}, 2'b11, 16'h1234); settle();
    issue(1'b1, {10'd4, 10'd2}, 2'b01, 16'hFFCD); settle();
    rd({10'd4, 10'd2}, 2'b11, q); settle();
    check(q == 16'h12CD, "R4 lower lane write only", q, 16'h12CD);
    rd({10'd4, 10'd2}, 2'b10, q); settle();
    check(q == 16'h1200, "R4 upper lane read, lower zero", q, 16'h1200);
  endtask

  task automatic t_zero_be();
    int c0 = cas_falls;
    issue(1'b1, {10'd4, 10'd2}, 2'b00, 16'h0000); settle();
    check(cas_falls == c0, "R5 no strobes for empty enables", cas_falls - c0, 0);
    check(mem[{4'd4, 4'd2}] == 16'h12CD, "R5 data untouched", mem[{4'd4,4'd2}], 16'h12CD);
  endtask

  task automatic t_page();
    int r0 = ras_falls;
    logic [15:0] q;
    issue(1'b1, {10'd6, 10'd0}, 2'b11, 16'h0600);
    issue(1'b1, {10'd6, 10'd1}, 2'b11, 16'h0601);
    issue(1'b0, {10'd6, 10'd0}, 2'b11, 16'h0);
    forever begin @(negedge clk); if (rd_valid) break; end
    q = rd_data; settle();
    check(ras_falls - r0 == 1, "R6 one row open for burst", ras_falls - r0, 1);
    check(q == 16'h0600 && mem[{4'd6,4'd1}] == 16'h0601, "R6 burst data", q, 16'h0600);
  endtask

  task automatic t_miss();
    int r0 = ras_falls;
    issue(1'b1, {10'd7, 10'd0}, 2'b11, 16'h0700);
    issue(1'b1, {10'd8, 10'd0}, 2'b11, 16'h0800); settle();
    check(ras_falls - r0 == 2, "R7 miss reopens row", ras_falls - r0, 2);
    check(gap_viol == 0, "R7 precharge gap", gap_viol, 0);
    check(early_viol == 0, "R8 early write", early_viol, 0);
  endtask

  task automatic t_refresh();
    int c0 = cbr;
    logic [15:0] q;
    @(negedge clk); ref_req = 1'b1;
    do @(negedge clk); while (!ref_ack);
    ref_req = 1'b0; settle();
    check(cbr - c0 == 1, "R9 refresh cycle", cbr - c0, 1);
    rd({10'd3, 10'd5}, 2'b11, q); settle();
    check(q == 16'hA55A, "R9 data kept", q, 16'hA55A);
  endtask

  task automatic t_ref_close();
    int r0 = ras_falls, c0 = cbr;
    issue(1'b1, {10'd9, 10'd1}, 2'b11, 16'h0901);
    ref_req = 1'b1;
    fork
      begin do @(negedge clk); while (!ref_ack); ref_req = 1'b0; end
      issue(1'b1, {10'd9, 10'd2}, 2'b11, 16'h0902);
    join
    settle();
    check(ras_falls - r0 == 2 && cbr - c0 == 1, "R10 refresh closes page", ras_falls - r0, 2);
  endtask

  task automatic t_timing();
    check(lat_seen > 0 && lat_viol == 0, "R11 read sample offset", lat_viol, 0);
    check(acks > 0 && ack_viol == 0, "R12 ack at strobe rise", ack_viol, 0);
    check(stby_viol == 0, "R1 standby bus quiet", stby_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word();
    t_bytes();
    t_zero_be();
    t_page();
    t_miss();
    t_refresh();
    t_ref_close();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule